// File: doc/BRIEF.md
# SPI Serial Bit-Clock Generator

This block derives the serial bit clock of an SPI master from the system clock. It uses two divide stages in cascade. The first is a prescaler that only takes even values from 2 to 254. The second divides by a programmable factor of 1 to 256, set as one plus a rate field of 0 to 255. The output period is the product of the two factors in system clocks. Because the prescale is always even, an odd overall ratio such as 5 cannot be produced. For example, an 80 MHz system clock can give 40, 20 or about 13.33 MHz, but never exactly 16 MHz.

The serial clock follows mode 0 framing. It idles low, the receiver samples on its rising edge and transmit data changes on its falling edge. Next to the clock level, the block gives a shift register two single-cycle strobes, one for each edge. The two configuration fields are captured only while the enable is low, so a running clock never changes rate in the middle of a frame.

Top module: `spi_bitclk_gen`

## Requirements
- R1: While enabled, sclk has a period of P × (1 + S) system clocks. P is the effective prescale and S is the rate field. The high phase and the low phase each last P/2 × (1 + S) clocks.
- R2: The effective prescale P is prescale_cfg with bit 0 forced to zero. A written value of 0 or 1 gives P = 2. An odd value of 7 gives P = 6.
- R3: The full range is reachable. Prescale 254 with rate 255 gives a period of 65024 clocks, and prescale 2 with rate 0 gives a period of 2 clocks.
- R4: After reset, and at every clock edge where en is sampled low, sclk is 0. Dropping en while sclk is high returns it low at the next edge, and neither strobe is asserted for that drop.
- R5: After en rises, the first rising edge of sclk comes at the (P/2 × (1 + S))-th clock edge where en is sampled high.
- R6: rise_stb is high for exactly the one cycle in which sclk first reads 1 after being 0.
- R7: fall_stb is high for exactly the one cycle in which sclk first reads 0 after a high phase while enabled.
- R8: Changes to prescale_cfg or rate_cfg while en is high have no effect on sclk. The new values take effect at the next enable after en has been low for at least one edge.
- R9: rise_stb and fall_stb are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds sclk idle and opens the configuration capture |
| prescale_cfg | input | PS_W (8) | First-stage divisor; bit 0 is ignored |
| rate_cfg | input | RATE_W (8) | Second-stage field S; the divide factor is 1 + S |
| sclk | output | 1 | Serial bit clock, idles low |
| rise_stb | output | 1 | One-cycle strobe when sclk rises |
| fall_stb | output | 1 | One-cycle strobe when sclk falls |

## Verification
The assertions assume that en is the only thing that opens the configuration capture. They also assume that reset is applied for at least one edge before the first comparison. The bench changes configuration and enable only on falling clock edges, and it holds reset over several edges at the start. Configuration is written while enabled only on purpose, to show that the captured divisors stay stable. Every period, latency and strobe expectation in the bench is worked out from P and S alone.

// File: rtl/spi_bitclk_gen.sv
module spi_bitclk_gen #(
  parameter int PS_W   = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PS_W-1:0]   prescale_cfg,
  input  logic [RATE_W-1:0] rate_cfg,
  output logic              sclk,
  output logic              rise_stb,
  output logic              fall_stb
);
  localparam int HALF_W = PS_W - 1;
  localparam logic [HALF_W-1:0] HALF_ONE  = {{(HALF_W-1){1'b0}}, 1'b1};
  localparam logic [HALF_W-1:0] HALF_ZERO = '0;

  logic [HALF_W-1:0] half_q;
  logic [RATE_W-1:0] rate_q;
  logic [HALF_W-1:0] pre_cnt;
  logic [RATE_W-1:0] post_cnt;

  wire [HALF_W-1:0] cfg_half  = prescale_cfg[PS_W-1:1];
  wire              pre_tick  = (pre_cnt == half_q - HALF_ONE);
  wire              post_wrap = (post_cnt == rate_q);
  wire              toggle    = pre_tick && post_wrap;

  // capture divisors only while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= HALF_ONE;
      rate_q <= '0;
    end else if (!en) begin
      half_q <= (cfg_half == HALF_ZERO) ? HALF_ONE : cfg_half;
      rate_q <= rate_cfg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
      sclk     <= 1'b0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      pre_cnt  <= pre_tick ? '0 : pre_cnt + HALF_ONE;
      if (pre_tick)
        post_cnt <= post_wrap ? '0 : post_cnt + 1'b1;
      sclk     <= sclk ^ toggle;
      rise_stb <= toggle && !sclk;
      fall_stb <= toggle && sclk;
    end
  end
endmodule

// File: rtl/spi_bitclk_gen_chk.sv
module spi_bitclk_gen_chk #(
  parameter int PS_W   = 8,
  parameter int RATE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              sclk,
  input logic              rise_stb,
  input logic              fall_stb,
  input logic [PS_W-2:0]   half_q,
  input logic [RATE_W-1:0] rate_q
);
  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sclk);

  // R6
  rise_match_chk: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> (sclk && !$past(sclk)));

  // R7
  fall_match_chk: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> (!sclk && $past(sclk)));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rise_stb && fall_stb));

  // R6
  edge_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && (sclk != $past(sclk))) |-> (rise_stb || fall_stb));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |-> ($stable(half_q) && $stable(rate_q)));

  // R2
  half_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    half_q != '0);
endmodule

bind spi_bitclk_gen spi_bitclk_gen_chk #(.PS_W(PS_W), .RATE_W(RATE_W)) chk (
  .clk(clk), .rst(rst), .en(en), .sclk(sclk), .rise_stb(rise_stb),
  .fall_stb(fall_stb), .half_q(half_q), .rate_q(rate_q)
);

// File: tb/spi_bitclk_gen_test.sv
module spi_bitclk_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [7:0] prescale_cfg = 8'd2;
  logic [7:0] rate_cfg = 8'd0;
  logic sclk, rise_stb, fall_stb;

  int n_checks = 0;
  int n_fails  = 0;
  int rise_bad = 0;
  int fall_bad = 0;
  logic prev_sclk = 1'b0;

  always #2.5 clk = ~clk;

  spi_bitclk_gen uut (
    .clk(clk), .rst(rst), .en(en), .prescale_cfg(prescale_cfg),
    .rate_cfg(rate_cfg), .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R6 R7 R9: strobe monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (rise_stb != (sclk && !prev_sclk)) rise_bad++;
      if (fall_stb && !(!sclk && prev_sclk)) fall_bad++;
      if (rise_stb && fall_stb) rise_bad++;
    end
    prev_sclk = sclk;
  end

  task automatic run_pair(input int ps, input int scr, input string req);
    int eff, half, cnt;
    eff  = (ps & 'hFE) < 2 ? 2 : (ps & 'hFE);
    half = (eff / 2) * (scr + 1);
    @(negedge clk);
    en = 1'b0;
    prescale_cfg = ps[7:0];
    rate_cfg = scr[7:0];
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!sclk && cnt < 70000);
    check(cnt == half, {req, " R5 first rise"}, cnt, half);
    check(rise_stb == 1'b1, {req, " R6 rise strobe"}, rise_stb, 1);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (sclk && cnt < 70000);
    check(cnt == half, {req, " R1 high phase"}, cnt, half);
    check(fall_stb == 1'b1, {req, " R7 fall strobe"}, fall_stb, 1);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!sclk && cnt < 70000);
    check(cnt == half, {req, " R1 low phase"}, cnt, half);
  endtask

  task automatic t_reset;
    check(sclk == 1'b0, "R4 reset sclk", sclk, 0);
    check(!rise_stb && !fall_stb, "R4 reset strobes", rise_stb + fall_stb, 0);
  endtask

  task automatic t_disable;
    run_pair(2, 1, "R4 pre");
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0, "R4 drop to idle", sclk, 0);
    check(!fall_stb && !rise_stb, "R4 no strobe on disable", fall_stb + rise_stb, 0);
    repeat (5) @(negedge clk);
    check(sclk == 1'b0, "R4 stays idle", sclk, 0);
  endtask

  task automatic t_live_change;
    int cnt;
    run_pair(4, 0, "R8 base");
    prescale_cfg = 8'd16;
    rate_cfg = 8'd3;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (sclk && cnt < 1000);
    check(cnt == 2, "R8 high unchanged", cnt, 2);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!sclk && cnt < 1000);
    check(cnt == 2, "R8 low unchanged", cnt, 2);
    run_pair(16, 3, "R8 reenable");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_pair(2, 0, "R3 min");
    run_pair(2, 1, "R1 p2s1");
    run_pair(6, 4, "R1 p6s4");
    run_pair(7, 2, "R2 odd7");
    run_pair(0, 0, "R2 zero");
    run_pair(1, 2, "R2 one");
    t_disable();
    t_live_change();
    run_pair(254, 255, "R3 max");
    check(rise_bad == 0, "R6 R9 rise monitor", rise_bad, 0);
    check(fall_bad == 0, "R7 fall monitor", fall_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule